// File: doc/BRIEF.md
# I2C Line Glitch Filter and Stop Flag

This block sits between the SCL and SDA pads and an I2C controller. Each raw line is first brought into the bus clock domain by a synchroniser. It then passes through a digital filter whose width software can change while the bus runs. A filtered line takes a new level only after that level has held for one clock more than the programmed width. A width of zero turns the filter off, so the line passes through after synchronisation with one register stage.

The block watches the two filtered lines for a STOP condition, which is SDA rising while SCL is high. A STOP sets a sticky stop flag. When the stop interrupt enable is on, the stop flag keeps setting a shared module interrupt flag, and that flag drives the interrupt request. Software writes 1 to clear each flag. It must clear the stop flag before the module flag, because while the stop flag is still set the module flag sets again.

A configuration write strobe loads the filter width and the stop interrupt enable, and can clear the stop flag in the same write. A separate strobe clears the module flag.

Top module: `i2c_glitch_stop`

## Requirements
- R1: After reset, scl_filt and sda_filt are 1, stop_flag, mod_flag, irq and stop_ie are 0, and flt_factor is 0.
- R2: With flt_factor 0, a level change on a raw input appears on its filtered output on the third rising clock edge after the change.
- R3: With flt_factor n (1 to 31), a pulse on SCL or SDA lasting n clock cycles or fewer never reaches the filtered output. A suppressed SDA low pulse while SCL is high does not set stop_flag.
- R4: With flt_factor n, a level that holds for n+1 cycles reaches the filtered output on clock edge n+3 after the raw change, and not before.
- R5: stop_flag sets one clock after sda_filt rises while scl_filt is 1. SDA falling while SCL is high does not set it, and neither does SDA rising while SCL is low.
- R6: A configuration write with bit 6 = 1 clears stop_flag. A write with bit 6 = 0 leaves it unchanged.
- R7: While stop_ie is 0, mod_flag does not set and irq stays 0, even with stop_flag set.
- R8: mod_flag sets on every clock in which stop_flag and stop_ie are both 1. A clear of mod_flag (flag_clr_we with flag_clr_wdata = 1) issued while stop_flag is 1 leaves it at 1. Once stop_flag is 0, the same clear drives it to 0.
- R9: irq equals mod_flag at all times.
- R10: A configuration write loads flt_factor from bits 4:0 and stop_ie from bit 5, and the new values show on the flt_factor and stop_ie outputs after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL line, asynchronous |
| sda_in | input | 1 | Raw SDA line, asynchronous |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 7 | Bits 4:0 filter width, bit 5 stop interrupt enable, bit 6 write-1 clear of stop flag |
| flag_clr_we | input | 1 | Module flag write strobe |
| flag_clr_wdata | input | 1 | 1 clears the module flag |
| scl_filt | output | 1 | Filtered SCL |
| sda_filt | output | 1 | Filtered SDA |
| flt_factor | output | 5 | Current filter width |
| stop_ie | output | 1 | Stop interrupt enable |
| stop_flag | output | 1 | Sticky STOP detected flag |
| mod_flag | output | 1 | Module interrupt flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is the exact boundary between a pulse of n cycles and one of n+1 cycles. Another is the clear order, in which the module flag has to be cleared while the stop flag is still set. The bench changes the raw pins on falling clock edges, so each pulse lasts a known whole number of clocks. It then samples the filtered line on the cycles just before and on the predicted change edge. For the clear order, it raises a real STOP with the enable on and issues the module flag clear first. It checks that the flag is still set, then clears the stop flag and the module flag in the correct order.

// File: rtl/i2c_glitch_pkg.sv
package i2c_glitch_pkg;
  localparam int LINE_SCL = 0;
  localparam int LINE_SDA = 1;
  localparam int NUM_LINES = 2;

  // A differing level is accepted once its hold count has reached the width.
  function automatic logic hold_expired(input int unsigned hold_cnt,
                                        input int unsigned width);
    return hold_cnt >= width;
  endfunction

  // STOP: data rises while clock is high.
  function automatic logic is_stop(input logic scl_now, input logic sda_now,
                                   input logic sda_prev);
    return scl_now & sda_now & ~sda_prev;
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/i2c_line_filter.sv
module i2c_line_filter
  import i2c_glitch_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          din,
  input  logic [CW-1:0] width,
  output logic          dout
);
  logic          level_q;
  logic [CW-1:0] hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q  <= 1'b1;
      hold_cnt <= '0;
    end else if (din == level_q) begin
      hold_cnt <= '0;
    end else if (hold_expired(32'(hold_cnt), 32'(width))) begin
      level_q  <= din;
      hold_cnt <= '0;
    end else begin
      hold_cnt <= hold_cnt + 1'b1;
    end
  end

  assign dout = level_q;
endmodule

// File: rtl/i2c_stop_flags.sv
module i2c_stop_flags
  import i2c_glitch_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  input  logic stop_ie,
  input  logic stop_clr,
  input  logic mod_clr,
  output logic stop_evt,
  output logic stop_flag,
  output logic mod_flag
);
  logic sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sda_prev <= 1'b1;
    else        sda_prev <= sda_f;
  end

  assign stop_evt = is_stop(scl_f, sda_f, sda_prev);

  // Set has priority over clear so that no STOP is lost.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stop_flag <= 1'b0;
    else if (stop_evt) stop_flag <= 1'b1;
    else if (stop_clr) stop_flag <= 1'b0;
  end

  // A pending enabled stop keeps re-setting the module flag.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    mod_flag <= 1'b0;
    else if (stop_flag && stop_ie) mod_flag <= 1'b1;
    else if (mod_clr)              mod_flag <= 1'b0;
  end
endmodule

// File: rtl/i2c_glitch_stop.sv
module i2c_glitch_stop
  import i2c_glitch_pkg::*;
#(
  parameter int FACT_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              cfg_we,
  input  logic [FACT_W+1:0] cfg_wdata,
  input  logic              flag_clr_we,
  input  logic              flag_clr_wdata,
  output logic              scl_filt,
  output logic              sda_filt,
  output logic [FACT_W-1:0] flt_factor,
  output logic              stop_ie,
  output logic              stop_flag,
  output logic              mod_flag,
  output logic              irq
);
  localparam int IE_BIT  = FACT_W;
  localparam int CLR_BIT = FACT_W + 1;

  logic [NUM_LINES-1:0] raw_lines;
  logic [NUM_LINES-1:0] sync_lines;
  logic [NUM_LINES-1:0] filt_lines;
  logic scl_sync, sda_sync;
  logic stop_evt;
  logic stop_clr, mod_clr;

  assign raw_lines[LINE_SCL] = scl_in;
  assign raw_lines[LINE_SDA] = sda_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_factor <= '0;
      stop_ie    <= 1'b0;
    end else if (cfg_we) begin
      flt_factor <= cfg_wdata[FACT_W-1:0];
      stop_ie    <= cfg_wdata[IE_BIT];
    end
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_lines[g]),
      .dout (sync_lines[g])
    );
    i2c_line_filter #(.CW(FACT_W)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (sync_lines[g]),
      .width(flt_factor),
      .dout (filt_lines[g])
    );
  end

  assign scl_sync = sync_lines[LINE_SCL];
  assign sda_sync = sync_lines[LINE_SDA];
  assign scl_filt = filt_lines[LINE_SCL];
  assign sda_filt = filt_lines[LINE_SDA];

  assign stop_clr = cfg_we & cfg_wdata[CLR_BIT];
  assign mod_clr  = flag_clr_we & flag_clr_wdata;

  i2c_stop_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_filt),
    .sda_f    (sda_filt),
    .stop_ie  (stop_ie),
    .stop_clr (stop_clr),
    .mod_clr  (mod_clr),
    .stop_evt (stop_evt),
    .stop_flag(stop_flag),
    .mod_flag (mod_flag)
  );

  assign irq = mod_flag;
endmodule

// File: rtl/i2c_glitch_stop_chk.sv
module i2c_glitch_stop_chk #(
  parameter int FACT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_sync,
  input logic              sda_sync,
  input logic              scl_filt,
  input logic              sda_filt,
  input logic              stop_evt,
  input logic              stop_flag,
  input logic              stop_ie,
  input logic              mod_flag,
  input logic              cfg_we,
  input logic [FACT_W+1:0] cfg_wdata
);
  // R3/R4: a filtered line only ever moves to the synchronised level.
  p_scl_to_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_filt != $past(scl_filt)) |-> (scl_filt == $past(scl_sync)));
  p_sda_to_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_filt != $past(sda_filt)) |-> (sda_filt == $past(sda_sync)));

  p_stop_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> stop_flag);

  p_zero_write_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_wdata[FACT_W+1] && stop_flag) |=> stop_flag);

  p_no_irq_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_ie && !mod_flag) |=> !mod_flag);

  p_reassert_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_flag && stop_ie) |=> mod_flag);
endmodule

bind i2c_glitch_stop i2c_glitch_stop_chk #(.FACT_W(FACT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_sync (scl_sync),
  .sda_sync (sda_sync),
  .scl_filt (scl_filt),
  .sda_filt (sda_filt),
  .stop_evt (stop_evt),
  .stop_flag(stop_flag),
  .stop_ie  (stop_ie),
  .mod_flag (mod_flag),
  .cfg_we   (cfg_we),
  .cfg_wdata(cfg_wdata)
);

// File: tb/sim_i2c_glitch_stop.sv
`timescale 1ns/100ps
module sim_i2c_glitch_stop;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_in = 1'b1, sda_in = 1'b1;
  logic       cfg_we = 1'b0;
  logic [6:0] cfg_wdata = '0;
  logic       flag_clr_we = 1'b0, flag_clr_wdata = 1'b0;
  logic       scl_filt, sda_filt, stop_ie, stop_flag, mod_flag, irq;
  logic [4:0] flt_factor;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  i2c_glitch_stop u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .flag_clr_we(flag_clr_we), .flag_clr_wdata(flag_clr_wdata),
    .scl_filt(scl_filt), .sda_filt(sda_filt), .flt_factor(flt_factor),
    .stop_ie(stop_ie), .stop_flag(stop_flag), .mod_flag(mod_flag), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_cfg(input logic clr, input logic ie, input logic [4:0] w);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = {clr, ie, w};
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_wdata = '0;
  endtask

  task automatic clear_mod();
    @(negedge clk);
    flag_clr_we = 1'b1;
    flag_clr_wdata = 1'b1;
    @(negedge clk);
    flag_clr_we = 1'b0;
    flag_clr_wdata = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 scl_filt", scl_filt, 1);
    check("R1 sda_filt", sda_filt, 1);
    check("R1 stop_flag", stop_flag, 0);
    check("R1 mod_flag", mod_flag, 0);
    check("R1 irq", irq, 0);
    check("R1 stop_ie", stop_ie, 0);
    check("R1 flt_factor", flt_factor, 0);
  endtask

  // Factor 0: bypass latency, plus STOP and no-STOP detection.
  task automatic t_bypass_stop();
    @(negedge clk);
    sda_in = 1'b0;
    cycles(2);
    check("R2 sda_filt before edge 3", sda_filt, 1);
    cycles(1);
    check("R2 sda_filt at edge 3", sda_filt, 0);
    cycles(3);
    check("R5 falling SDA no stop", stop_flag, 0);
    sda_in = 1'b1;
    cycles(3);
    check("R2 sda_filt rise at edge 3", sda_filt, 1);
    check("R5 stop_flag not yet", stop_flag, 0);
    cycles(1);
    check("R5 stop_flag set", stop_flag, 1);
    cycles(3);
    check("R7 mod_flag with ie 0", mod_flag, 0);
    check("R7 irq with ie 0", irq, 0);
    write_cfg(1'b0, 1'b0, 5'd0);
    check("R6 zero write keeps flag", stop_flag, 1);
    write_cfg(1'b1, 1'b0, 5'd0);
    check("R6 one write clears flag", stop_flag, 0);
    // SDA rising while SCL is low is not a STOP.
    scl_in = 1'b0;
    cycles(5);
    sda_in = 1'b0;
    cycles(5);
    sda_in = 1'b1;
    cycles(5);
    scl_in = 1'b1;
    cycles(5);
    check("R5 SDA rise with SCL low", stop_flag, 0);
  endtask

  task automatic t_filter(input int n);
    logic stayed;
    write_cfg(1'b0, 1'b0, 5'(n));
    check("R10 flt_factor readback", flt_factor, n);
    check("R10 stop_ie readback", stop_ie, 0);
    // SCL pulse of n cycles: must be absorbed.
    stayed = 1'b1;
    scl_in = 1'b0;
    for (int i = 1; i <= 2 * n + 6; i++) begin
      @(negedge clk);
      if (i == n) scl_in = 1'b1;
      if (scl_filt !== 1'b1) stayed = 1'b0;
    end
    check($sformatf("R3 scl pulse %0d absorbed", n), stayed, 1);
    // SDA low pulse of n cycles with SCL high: no STOP.
    stayed = 1'b1;
    sda_in = 1'b0;
    for (int i = 1; i <= 2 * n + 6; i++) begin
      @(negedge clk);
      if (i == n) sda_in = 1'b1;
      if (sda_filt !== 1'b1) stayed = 1'b0;
    end
    check($sformatf("R3 sda pulse %0d absorbed", n), stayed, 1);
    check("R3 no stop from glitch", stop_flag, 0);
    // SCL pulse of n+1 cycles: passes, exact latency.
    scl_in = 1'b0;
    for (int i = 1; i <= n + 3; i++) begin
      @(negedge clk);
      if (i == n + 1) scl_in = 1'b1;
      if (i == n + 2) check($sformatf("R4 n=%0d before edge", n), scl_filt, 1);
      if (i == n + 3) check($sformatf("R4 n=%0d at edge", n), scl_filt, 0);
    end
    cycles(n + 6);
    check("R4 scl returns high", scl_filt, 1);
  endtask

  task automatic t_irq_order();
    write_cfg(1'b0, 1'b1, 5'd0);
    check("R10 stop_ie set", stop_ie, 1);
    sda_in = 1'b0;
    cycles(5);
    sda_in = 1'b1;
    cycles(6);
    check("R8 stop_flag", stop_flag, 1);
    check("R8 mod_flag set", mod_flag, 1);
    check("R9 irq follows", irq, 1);
    clear_mod();
    check("R8 wrong order reasserts", mod_flag, 1);
    write_cfg(1'b1, 1'b1, 5'd0);
    check("R8 stop_flag cleared", stop_flag, 0);
    clear_mod();
    check("R8 right order clears", mod_flag, 0);
    check("R9 irq cleared", irq, 0);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        check("watchdog", 1, 0);
        report();
      end
    join_none
    cycles(3);
    t_reset();
    rst_n = 1'b1;
    cycles(2);
    t_reset();
    t_bypass_stop();
    t_filter(1);
    t_filter(4);
    t_filter(31);
    t_irq_order();
    report();
  end
endmodule